// File: doc/BRIEF.md
# Flash erase command controller

This block is the command front end of a small NOR-style flash model. Software gives it byte-wide command writes on a simple bus. A setup code followed by a confirm code starts one of three erase kinds: the whole array, one block, or one sector. For block and sector erase, the address on the confirm write picks the region. The block checks the supply level and the per-block lock bits before it starts the internal erase engine. The engine waits a fixed number of cycles and then sets one word to all ones on each clock.

Once an erase command has been issued, reads on the bus return the status byte instead of array data. While an erase runs, the controller filters incoming writes. A chip erase accepts only the status-read code. A block or sector erase also accepts a suspend code, which freezes the engine. Error conditions set sticky status flags and return the controller to idle without changing the array.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset, array word i holds (37*i+5) mod 256. Reads return array data at `bus_addr`. Writing code 0x70 makes reads return the status byte, which is 0x80 after reset.
- R2: An erase starts only when a setup code (0x20 block, 0x32 sector, 0x80 chip) is followed by the confirm code 0xD0 on the next write. Status bit 7 (ready) is 0 from the clock edge after the confirm write until the erase completes. A lone 0xD0 written in idle has no effect.
- R3: The confirm write's address selects the region. A block is 16 words and is chosen by address bits [5:4]. A sector is 4 words and is chosen by address bits [5:2].
- R4: An erase sets every word of the target region to 0xFF and leaves all other words unchanged. Ready returns to 1 when the last word is written.
- R5: From the write that completes a setup/confirm pair, reads return the status byte. While the block is idle or suspended, code 0xFF switches reads back to array data.
- R6: Chip erase covers all 64 words. It is accepted only when `if_mux_mode` is 1; otherwise a 0x80 write is ignored.
- R7: While a chip erase runs, every write is ignored. This includes 0xB0 and 0xFF, so reads keep returning status and the erase runs to completion.
- R8: While a block or sector erase runs, only 0x70 and suspend (0xB0) take effect. Suspend freezes the erase, and the status byte then shows bits 7 and 6 set.
- R9: When `if_mux_mode` is 0 and the lock bit of the target block is set, a block or sector erase aborts with the array unchanged. A sector is checked against the block that contains it. The abort sets status bits 5 and 1. Lock bits have no effect when `if_mux_mode` is 1.
- R10: A confirm while `vpp_high` is 0 skips the erase and sets status bits 5 and 3.
- R11: A setup code followed by any byte other than 0xD0 sets status bits 5 and 4 and returns the controller to idle.
- R12: Error bits 5, 4, 3 and 1 stay set until the clear code 0x50 is written in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe; one command byte per cycle |
| bus_addr | input | ADDR_W | Word address for reads and erase targets |
| bus_wdata | input | 8 | Command byte |
| bus_rdata | output | WORD_W | Array word or status byte |
| if_mux_mode | input | 1 | 1 = address-multiplexed mode, 0 = firmware-hub/LPC mode |
| blk_lock | input | 2**BLK_W | Per-block erase lock |
| vpp_high | input | 1 | Programming supply at its high level |

## Verification
The bench builds the block with its default geometry: 64 words of 8 bits, four blocks and sixteen sectors, and an erase start latency of 4 cycles. With 4-word sectors and 16-word blocks, the words just outside each erased region can be read back in a few cycles. A whole chip erase finishes in under 70 cycles, so waiting for ready on every erase kind is cheap. The latency of 4 cycles leaves room to land a suspend before the first word is cleared, which makes the frozen-engine case observable at the array.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
   localparam int CMD_W = 8;

   localparam logic [CMD_W-1:0] CMD_BLK_SETUP = 8'h20;
   localparam logic [CMD_W-1:0] CMD_SEC_SETUP = 8'h32;
   localparam logic [CMD_W-1:0] CMD_CHIP_SETUP = 8'h80;
   localparam logic [CMD_W-1:0] CMD_CONFIRM = 8'hD0;
   localparam logic [CMD_W-1:0] CMD_RD_STATUS = 8'h70;
   localparam logic [CMD_W-1:0] CMD_SUSPEND = 8'hB0;
   localparam logic [CMD_W-1:0] CMD_RD_ARRAY = 8'hFF;
   localparam logic [CMD_W-1:0] CMD_CLR_STATUS = 8'h50;

   localparam int SB_READY = 7;
   localparam int SB_SUSP = 6;
   localparam int SB_ERASE_ERR = 5;
   localparam int SB_SEQ_ERR = 4;
   localparam int SB_VPP_ERR = 3;
   localparam int SB_PROT_ERR = 1;

   typedef enum logic [1:0] {ER_NONE, ER_CHIP, ER_BLOCK, ER_SECTOR} erase_kind_t;
   typedef enum logic [1:0] {FS_IDLE, FS_SETUP, FS_BUSY, FS_SUSP} fsm_state_t;

   function automatic logic [31:0] reset_word(input int idx);
      return 32'(37 * idx + 5);
   endfunction
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
   import flash_erase_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int BLK_W = 2,
   parameter int SEC_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic [CMD_W-1:0]         wdata,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic                     mux_mode,
   input  logic [(1<<BLK_W)-1:0]    lock,
   input  logic                     vpp_ok,
   input  logic                     eng_busy,
   output logic                     start,
   output logic [ADDR_W-1:0]        range_lo,
   output logic [ADDR_W-1:0]        range_hi,
   output logic                     pause,
   output logic [7:0]               status,
   output logic                     show_status,
   output fsm_state_t               state,
   output erase_kind_t              kind
);
   localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'((1 << (ADDR_W - BLK_W)) - 1);
   localparam logic [ADDR_W-1:0] SEC_MASK = ADDR_W'((1 << (ADDR_W - SEC_W)) - 1);
   localparam logic [ADDR_W-1:0] ALL_MASK = '1;

   fsm_state_t  st_q;
   erase_kind_t kind_q;
   logic        show_q;
   logic        e_erase_q, e_seq_q, e_vpp_q, e_prot_q;
   logic [ADDR_W-1:0] span;
   logic        blocked;
   logic        confirm;

   always_comb begin
      unique case (kind_q)
         ER_BLOCK:  span = BLK_MASK;
         ER_SECTOR: span = SEC_MASK;
         default:   span = ALL_MASK;
      endcase
   end

   assign range_lo = waddr & ~span;
   assign range_hi = waddr | span;
   assign blocked  = (kind_q != ER_CHIP) && !mux_mode && lock[waddr[ADDR_W-1 -: BLK_W]];
   assign confirm  = (st_q == FS_SETUP) && wr && (wdata == CMD_CONFIRM);
   assign start    = confirm && vpp_ok && !blocked;
   assign pause    = (st_q == FS_SUSP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= FS_IDLE;
         kind_q    <= ER_NONE;
         show_q    <= 1'b0;
         e_erase_q <= 1'b0;
         e_seq_q   <= 1'b0;
         e_vpp_q   <= 1'b0;
         e_prot_q  <= 1'b0;
      end else begin
         unique case (st_q)
            FS_IDLE: begin
               if (wr) begin
                  case (wdata)
                     CMD_BLK_SETUP: begin
                        kind_q <= ER_BLOCK;
                        st_q   <= FS_SETUP;
                     end
                     CMD_SEC_SETUP: begin
                        kind_q <= ER_SECTOR;
                        st_q   <= FS_SETUP;
                     end
                     CMD_CHIP_SETUP: begin
                        if (mux_mode) begin
                           kind_q <= ER_CHIP;
                           st_q   <= FS_SETUP;
                        end
                     end
                     CMD_CLR_STATUS: begin
                        e_erase_q <= 1'b0;
                        e_seq_q   <= 1'b0;
                        e_vpp_q   <= 1'b0;
                        e_prot_q  <= 1'b0;
                     end
                     CMD_RD_STATUS: show_q <= 1'b1;
                     CMD_RD_ARRAY:  show_q <= 1'b0;
                     default: ;
                  endcase
               end
            end
            FS_SETUP: begin
               if (wr) begin
                  show_q <= 1'b1;
                  if (wdata != CMD_CONFIRM) begin
                     e_erase_q <= 1'b1;
                     e_seq_q   <= 1'b1;
                     st_q      <= FS_IDLE;
                  end else if (!vpp_ok) begin
                     e_erase_q <= 1'b1;
                     e_vpp_q   <= 1'b1;
                     st_q      <= FS_IDLE;
                  end else if (blocked) begin
                     e_erase_q <= 1'b1;
                     e_prot_q  <= 1'b1;
                     st_q      <= FS_IDLE;
                  end else begin
                     st_q <= FS_BUSY;
                  end
               end
            end
            FS_BUSY: begin
               if (!eng_busy) begin
                  st_q <= FS_IDLE;
               end else if (wr && wdata == CMD_SUSPEND && kind_q != ER_CHIP) begin
                  st_q <= FS_SUSP;
               end
            end
            FS_SUSP: begin
               if (wr && wdata == CMD_RD_STATUS) begin
                  show_q <= 1'b1;
               end else if (wr && wdata == CMD_RD_ARRAY) begin
                  show_q <= 1'b0;
               end
            end
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   always_comb begin
      status               = '0;
      status[SB_READY]     = (st_q != FS_BUSY);
      status[SB_SUSP]      = (st_q == FS_SUSP);
      status[SB_ERASE_ERR] = e_erase_q;
      status[SB_SEQ_ERR]   = e_seq_q;
      status[SB_VPP_ERR]   = e_vpp_q;
      status[SB_PROT_ERR]  = e_prot_q;
   end

   assign show_status = show_q;
   assign state       = st_q;
   assign kind        = kind_q;
endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine #(
   parameter int ADDR_W = 6,
   parameter int START_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic              pause,
   output logic              busy,
   output logic              clr_en,
   output logic [ADDR_W-1:0] clr_addr
);
   logic              busy_q;
   logic [ADDR_W-1:0] cur_q, last_q;
   logic              lat_done;

   generate
      if (START_LAT == 0) begin : g_no_lat
         assign lat_done = 1'b1;
      end else begin : g_lat
         localparam int LAT_W = $clog2(START_LAT + 1);
         logic [LAT_W-1:0] lat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lat_q <= '0;
            end else if (start) begin
               lat_q <= LAT_W'(START_LAT);
            end else if (busy_q && !pause && lat_q != '0) begin
               lat_q <= lat_q - 1'b1;
            end
         end
         assign lat_done = (lat_q == '0);
      end
   endgenerate

   assign clr_en   = busy_q && !pause && lat_done;
   assign clr_addr = cur_q;
   assign busy     = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cur_q  <= '0;
         last_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cur_q  <= lo;
         last_q <= hi;
      end else if (clr_en) begin
         if (cur_q == last_q) begin
            busy_q <= 1'b0;
         end else begin
            cur_q <= cur_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/flash_word_array.sv
module flash_word_array
   import flash_erase_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_addr,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= WORD_W'(reset_word(i));
         end
      end else if (clr_en) begin
         mem_q[clr_addr] <= '1;
      end
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
   import flash_erase_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 8,
   parameter int BLK_W = 2,
   parameter int SEC_W = 4,
   parameter int START_LAT = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [CMD_W-1:0]      bus_wdata,
   output logic [WORD_W-1:0]     bus_rdata,
   input  logic                  if_mux_mode,
   input  logic [(1<<BLK_W)-1:0] blk_lock,
   input  logic                  vpp_high
);
   generate
      if (BLK_W < 1 || SEC_W <= BLK_W || SEC_W > ADDR_W) begin : g_bad_geometry
         $error("flash_erase_ctl: need 1 <= BLK_W < SEC_W <= ADDR_W");
      end
      if (WORD_W < 8) begin : g_bad_width
         $error("flash_erase_ctl: WORD_W must hold the status byte");
      end
      if (START_LAT < 0) begin : g_bad_lat
         $error("flash_erase_ctl: START_LAT must not be negative");
      end
   endgenerate

   logic              eng_start, eng_pause, eng_busy, clr_en;
   logic [ADDR_W-1:0] range_lo, range_hi, clr_addr;
   logic [7:0]        status;
   logic              show_status;
   logic [WORD_W-1:0] arr_rdata;
   fsm_state_t        fsm_state;
   erase_kind_t       op_kind;

   flash_cmd_fsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .SEC_W(SEC_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr(bus_we), .wdata(bus_wdata), .waddr(bus_addr),
      .mux_mode(if_mux_mode), .lock(blk_lock), .vpp_ok(vpp_high), .eng_busy(eng_busy),
      .start(eng_start), .range_lo(range_lo), .range_hi(range_hi), .pause(eng_pause),
      .status(status), .show_status(show_status), .state(fsm_state), .kind(op_kind)
   );

   flash_erase_engine #(.ADDR_W(ADDR_W), .START_LAT(START_LAT)) u_engine (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .lo(range_lo), .hi(range_hi),
      .pause(eng_pause), .busy(eng_busy), .clr_en(clr_en), .clr_addr(clr_addr)
   );

   flash_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
      .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .clr_addr(clr_addr),
      .raddr(bus_addr), .rdata(arr_rdata)
   );

   assign bus_rdata = show_status ? WORD_W'(status) : arr_rdata;
endmodule

// File: rtl/flash_erase_ctl_chk.sv
module flash_erase_ctl_chk
   import flash_erase_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_we,
   input logic [7:0]  bus_wdata,
   input logic        if_mux_mode,
   input logic        vpp_high,
   input logic        eng_start,
   input logic        clr_en,
   input logic [7:0]  status,
   input logic        show_status,
   input fsm_state_t  fsm_state,
   input erase_kind_t op_kind
);
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !status[SB_READY]); // R2

   AST_CLEAR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> !status[SB_READY]); // R4

   AST_STATUS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !status[SB_READY] |-> show_status); // R5

   AST_CHIP_NEEDS_MUX: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == FS_IDLE && bus_we && bus_wdata == CMD_CHIP_SETUP && !if_mux_mode)
      |=> fsm_state == FS_IDLE); // R6

   AST_CHIP_NO_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == FS_BUSY && op_kind == ER_CHIP) |=> fsm_state != FS_SUSP); // R7

   AST_SUSPEND_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      fsm_state == FS_SUSP |-> !clr_en); // R8

   AST_PROT_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[SB_PROT_ERR]) |-> status[SB_READY] && status[SB_ERASE_ERR]); // R9

   AST_NO_START_LOW_VPP: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> vpp_high); // R10

   AST_SEQ_ERR_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[SB_SEQ_ERR]) |-> status[SB_ERASE_ERR] && $past(fsm_state == FS_SETUP)); // R11

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[SB_ERASE_ERR]) |-> $past(bus_we && bus_wdata == CMD_CLR_STATUS)); // R12
endmodule

bind flash_erase_ctl flash_erase_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
   .if_mux_mode(if_mux_mode), .vpp_high(vpp_high), .eng_start(eng_start),
   .clr_en(clr_en), .status(status), .show_status(show_status),
   .fsm_state(fsm_state), .op_kind(op_kind)
);

// File: tb/flash_erase_ctl_tb.sv
module flash_erase_ctl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       if_mux_mode = 1'b1;
   logic [3:0] blk_lock = 4'hF;
   logic       vpp_high = 1'b1;

   int n_checks = 0;
   int n_errors = 0;

   always #2 clk = ~clk;

   flash_erase_ctl #(.ADDR_W(6), .WORD_W(8), .BLK_W(2), .SEC_W(4), .START_LAT(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .if_mux_mode(if_mux_mode),
      .blk_lock(blk_lock), .vpp_high(vpp_high)
   );

   function automatic logic [7:0] pat(input int i);
      return 8'(37 * i + 5);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] cmd, input logic [5:0] a);
      @(negedge clk);
      bus_we = 1'b1;
      bus_wdata = cmd;
      bus_addr = a;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [5:0] a, input logic [7:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic wait_ready(input string req);
      bit seen = 1'b0;
      for (int k = 0; k < 500 && !seen; k++) begin
         @(negedge clk);
         #1;
         if (bus_rdata[7]) seen = 1'b1;
      end
      check(req, 8'(seen), 8'd1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // op: 0 write, 1 read literal, 2 read reset pattern, 3 wait for ready
   localparam int NV = 23;
   localparam logic [23:0] VEC [NV] = '{
      {2'd2, 6'd5,  8'h00, 8'h00},  // R1 array data after reset
      {2'd0, 6'd0,  8'h70, 8'h00},
      {2'd1, 6'd0,  8'h00, 8'h80},  // R1 status after reset
      {2'd0, 6'd0,  8'hFF, 8'h00},
      {2'd2, 6'd9,  8'h00, 8'h00},  // R5 back to array
      {2'd0, 6'd0,  8'h32, 8'h00},
      {2'd0, 6'd9,  8'hD0, 8'h00},  // R3 sector 2 -> words 8..11
      {2'd1, 6'd0,  8'h00, 8'h00},  // R2 busy right after confirm
      {2'd3, 6'd0,  8'h00, 8'h00},
      {2'd1, 6'd0,  8'h00, 8'h80},  // R4 ready again
      {2'd0, 6'd0,  8'hFF, 8'h00},
      {2'd1, 6'd8,  8'h00, 8'hFF},  // R4
      {2'd1, 6'd11, 8'h00, 8'hFF},  // R4
      {2'd2, 6'd7,  8'h00, 8'h00},  // R4 neighbour untouched
      {2'd2, 6'd12, 8'h00, 8'h00},  // R4 neighbour untouched
      {2'd0, 6'd0,  8'h20, 8'h00},
      {2'd0, 6'd33, 8'hD0, 8'h00},  // R3 block 2 -> words 32..47, lock ignored in mux mode (R9)
      {2'd3, 6'd0,  8'h00, 8'h00},
      {2'd0, 6'd0,  8'hFF, 8'h00},
      {2'd1, 6'd32, 8'h00, 8'hFF},  // R3
      {2'd1, 6'd47, 8'h00, 8'hFF},  // R3
      {2'd2, 6'd31, 8'h00, 8'h00},  // R3
      {2'd2, 6'd48, 8'h00, 8'h00}   // R3
   };

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got 0x00 expected 0x01");
         end
         begin
            do_reset();
            // table-driven sequences, mux mode, all blocks locked
            for (int v = 0; v < NV; v++) begin
               logic [1:0] op;
               logic [5:0] a;
               logic [7:0] d, e;
               {op, a, d, e} = VEC[v];
               case (op)
                  2'd0: wr(d, a);
                  2'd1: rd("R4/table", a, e);
                  2'd2: rd("R1/table", a, pat(int'(a)));
                  default: wait_ready("R4 ready");
               endcase
            end

            // R9 protection abort in LPC mode
            if_mux_mode = 1'b0;
            blk_lock = 4'b0010;
            wr(8'h32, 6'd0);
            wr(8'hD0, 6'd20);
            rd("R9 prot status", 6'd0, 8'hA2);
            wr(8'hFF, 6'd0);
            rd("R9 array kept", 6'd20, pat(20));
            wr(8'h70, 6'd0);
            rd("R12 sticky", 6'd0, 8'hA2);
            wr(8'h50, 6'd0);
            rd("R12 cleared", 6'd0, 8'h80);
            // unlocked block in LPC mode still erases
            wr(8'h20, 6'd0);
            wr(8'hD0, 6'd50);
            wait_ready("R9 unlocked ready");
            wr(8'hFF, 6'd0);
            rd("R9 unlocked erased", 6'd48, 8'hFF);

            // R6 chip erase ignored outside mux mode; lone confirm ignored (R2)
            wr(8'h80, 6'd0);
            wr(8'hD0, 6'd0);
            wr(8'h70, 6'd0);
            rd("R6 no chip erase", 6'd0, 8'h80);
            wr(8'hFF, 6'd0);
            rd("R6 word 0 kept", 6'd0, pat(0));

            // R11 sequence error
            if_mux_mode = 1'b1;
            wr(8'h20, 6'd0);
            wr(8'h55, 6'd0);
            rd("R11 seq status", 6'd0, 8'hB0);
            wr(8'h50, 6'd0);
            rd("R11 cleared", 6'd0, 8'h80);

            // R10 supply low
            vpp_high = 1'b0;
            wr(8'h20, 6'd0);
            wr(8'hD0, 6'd0);
            rd("R10 vpp status", 6'd0, 8'hA8);
            wr(8'hFF, 6'd0);
            rd("R10 array kept", 6'd0, pat(0));
            vpp_high = 1'b1;
            wr(8'h50, 6'd0);

            // R8 suspend freezes block erase
            wr(8'h20, 6'd0);
            wr(8'hD0, 6'd2);
            wr(8'hB0, 6'd0);
            rd("R8 suspended", 6'd0, 8'hC0);
            repeat (30) @(negedge clk);
            rd("R8 still suspended", 6'd0, 8'hC0);
            wr(8'hFF, 6'd0);
            rd("R8 word 0 frozen", 6'd0, pat(0));
            rd("R8 word 15 frozen", 6'd15, pat(15));

            // R7 chip erase filters every write
            do_reset();
            rd("R1 reset array", 6'd0, pat(0));
            wr(8'h80, 6'd0);
            wr(8'hD0, 6'd0);
            wr(8'hB0, 6'd0);
            wr(8'hFF, 6'd0);
            wr(8'h20, 6'd0);
            rd("R7 busy status", 6'd0, 8'h00);
            wait_ready("R7 ready");
            rd("R7 not suspended", 6'd0, 8'h80);
            wr(8'hFF, 6'd0);
            rd("R6 chip word 0", 6'd0, 8'hFF);
            rd("R6 chip word 30", 6'd30, 8'hFF);
            rd("R6 chip word 63", 6'd63, 8'hFF);

            // R8 sector erase ignores read-array while busy
            do_reset();
            wr(8'h32, 6'd0);
            wr(8'hD0, 6'd5);
            wr(8'hFF, 6'd0);
            rd("R8 ignored 0xFF", 6'd0, 8'h00);
            wait_ready("R8 ready");
            wr(8'hFF, 6'd0);
            rd("R3 sector lo", 6'd4, 8'hFF);
            rd("R3 sector hi", 6'd7, 8'hFF);
            rd("R4 below", 6'd3, pat(3));
            rd("R4 above", 6'd8, pat(8));
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule